// File: doc/BRIEF.md
# SPI Byte Exchange Port

This block lets a CPU talk to an SPI device one byte per register access. Storing a byte into the data register starts a full-duplex exchange: the byte leaves on MOSI, most significant bit first, while eight bits arrive on MISO and are collected into a receive register. Reading a separate pull register starts the same exchange but sends all ones. Software can then read the byte it received. This is the usual way to fetch data from a serial flash once a read command has been issued.

The serial clock comes from the system clock through a fixed divider, set by parameter to divide by 2 or by 4. The port uses SPI mode 0. A one-byte holding register takes a request that arrives during a transfer, so two stores in a row run without a gap on the serial clock. The chip-select line is a plain control bit. Software asserts it around a multi-byte command and releases it when the command is done.

Top module: `spi_byte_port`

## Requirements
- R1: A write to address 0 starts an exchange that shifts the written byte out on MOSI, MSB first. When the exchange completes, the eight bits sampled from MISO, MSB first, are stored in the receive register.
- R2: A read of address 1 returns the current receive byte on the same cycle and starts an exchange that sends 0xFF. The incoming byte replaces the receive byte.
- R3: One byte exchange lasts exactly 8*CLK_DIV system cycles. Status bit 0 (busy) is 1 for exactly that long, SCLK is high for 4*CLK_DIV of those cycles, and CLK_DIV is 2 or 4.
- R4: SPI mode 0. SCLK is low whenever no exchange runs, MOSI never changes on a rising SCLK edge, MISO is taken on the rising edge, and MOSI is 1 while idle.
- R5: A start request that arrives during an exchange goes into a one-byte holding slot and sets status bit 1. It begins the cycle the current byte ends, so busy stays high with no idle cycle between the two bytes.
- R6: A start request that arrives while the holding slot is full is dropped. It sends nothing and does not change the receive byte.
- R7: Bit 0 of the control register at address 3 drives CS_n directly. It resets to 1 and reads back at address 3.
- R8: Reading address 0 returns the last received byte and starts no exchange. The receive byte changes only when an exchange completes.
- R9: Writes to address 1 and address 2 have no effect. Reading address 2 starts no exchange.
- R10: After reset, busy and holding are 0, the receive byte is 0x00, SCLK is 0, MOSI is 1 and CS_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 pull, 2 status, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A bench slave answers every exchange with a byte computed from a running index. This catches a stale receive byte, bits in the wrong order and a byte credited to the wrong exchange. All 256 byte values are pushed through the holding slot back to back. This separates a correct MSB-first shift from bit-order errors and from lost or doubled bytes. Short patterns cover the rest: a single store, a pull read, a pair of stores and a triple of stores. They show the exact busy length, the seamless hand-over from the holding slot and the dropped third request. Accesses to addresses that must do nothing are followed by a check of the SCLK edge count and the receive byte.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA = 2'd0,
        SEL_PULL = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam byte_t FILL_BYTE = '1;

    typedef struct packed {
        logic  valid;
        byte_t data;
    } xfer_req_t;

    typedef struct packed {
        logic hold_full;
        logic busy;
    } stat_t;

    function automatic byte_t pack_status(stat_t s);
        return {{(BYTE_W-2){1'b0}}, s.hold_full, s.busy};
    endfunction

endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_xchg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  xfer_req_t feed,
    output logic      feed_ready,
    output logic      sclk,
    output logic      mosi,
    input  logic      miso,
    output logic      busy,
    output logic      done,
    output byte_t     rx_data
);

    localparam int HALF  = CLK_DIV / 2;
    localparam int PH_W  = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(BYTE_W);

    if (CLK_DIV != 2 && CLK_DIV != 4) begin : g_bad_div
        $error("CLK_DIV must be 2 or 4");
    end

    logic [PH_W-1:0]  ph_cnt;
    logic [BIT_W-1:0] bit_idx;
    byte_t            tx_sr;
    byte_t            rx_sr;
    logic             sclk_q;
    logic             busy_q;
    logic             ph_end;
    logic             last_fall;
    logic             load;

    always_comb begin
        ph_end     = (ph_cnt == PH_W'(HALF-1));
        last_fall  = busy_q && sclk_q && ph_end && (bit_idx == BIT_W'(BYTE_W-1));
        feed_ready = !busy_q || last_fall;
        load       = feed.valid && feed_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            ph_cnt  <= '0;
            bit_idx <= '0;
            tx_sr   <= '1;
            rx_sr   <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            sclk_q  <= 1'b0;
            ph_cnt  <= '0;
            bit_idx <= '0;
            tx_sr   <= feed.data;
        end else if (last_fall) begin
            busy_q  <= 1'b0;
            sclk_q  <= 1'b0;
            ph_cnt  <= '0;
            tx_sr   <= '1;
        end else if (busy_q) begin
            if (ph_end) begin
                ph_cnt <= '0;
                sclk_q <= !sclk_q;
                if (!sclk_q) begin
                    rx_sr <= {rx_sr[BYTE_W-2:0], miso};
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b1};
                end
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_sr[BYTE_W-1];
    assign busy    = busy_q;
    assign done    = last_fall;
    assign rx_data = rx_sr;

    AST_MOSI_STILL_AT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk_q) |-> $stable(tx_sr[BYTE_W-1])); // R4

    AST_SCLK_LOW_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> !sclk_q); // R4

    AST_END_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> $past(sclk_q)); // R3

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
    import spi_xchg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  byte_t             bus_wdata,
    output byte_t             bus_rdata,
    output xfer_req_t         feed,
    input  logic              feed_ready,
    input  logic              eng_busy,
    input  logic              done,
    input  byte_t             rx_data,
    output logic              cs_n
);

    reg_sel_e  sel;
    logic      wr_acc;
    logic      rd_acc;
    xfer_req_t req;
    byte_t     hold_q;
    logic      hold_full_q;
    logic      cs_q;
    byte_t     rx_q;
    stat_t     stat;

    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        wr_acc    = bus_sel && bus_wr;
        rd_acc    = bus_sel && !bus_wr;
        req.valid = (wr_acc && sel == SEL_DATA) || (rd_acc && sel == SEL_PULL);
        req.data  = wr_acc ? bus_wdata : FILL_BYTE;
        feed.valid = hold_full_q || req.valid;
        feed.data  = hold_full_q ? hold_q : req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full_q <= 1'b0;
            hold_q      <= '0;
            cs_q        <= 1'b1;
            rx_q        <= '0;
        end else begin
            if (wr_acc && sel == SEL_CTRL) begin
                cs_q <= bus_wdata[0];
            end
            if (done) begin
                rx_q <= rx_data;
            end
            if (hold_full_q) begin
                if (feed_ready) begin
                    hold_full_q <= req.valid;
                    if (req.valid) begin
                        hold_q <= req.data;
                    end
                end
            end else if (req.valid && !feed_ready) begin
                hold_full_q <= 1'b1;
                hold_q      <= req.data;
            end
        end
    end

    always_comb begin
        stat.hold_full = hold_full_q;
        stat.busy      = eng_busy;
        unique case (sel)
            SEL_DATA, SEL_PULL: bus_rdata = rx_q;
            SEL_STAT:           bus_rdata = pack_status(stat);
            default:            bus_rdata = {{(BYTE_W-1){1'b0}}, cs_q};
        endcase
    end

    assign cs_n = cs_q;

    AST_HOLD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        hold_full_q |-> eng_busy); // R5

    AST_CS_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && sel == SEL_CTRL) |=> (cs_n == $past(bus_wdata[0]))); // R7

    AST_RX_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(rx_q)); // R8

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_xchg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);

    xfer_req_t feed;
    logic      feed_ready;
    logic      eng_busy;
    logic      eng_done;
    byte_t     eng_rx;

    spi_reg_front u_front (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .feed       (feed),
        .feed_ready (feed_ready),
        .eng_busy   (eng_busy),
        .done       (eng_done),
        .rx_data    (eng_rx),
        .cs_n       (spi_cs_n)
    );

    spi_shift_engine #(.CLK_DIV(CLK_DIV)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .feed       (feed),
        .feed_ready (feed_ready),
        .sclk       (spi_sclk),
        .mosi       (spi_mosi),
        .miso       (spi_miso),
        .busy       (eng_busy),
        .done       (eng_done),
        .rx_data    (eng_rx)
    );

endmodule

// File: tb/tb_spi_byte_port.sv
module tb_spi_byte_port;

    localparam int D  = 4;
    localparam int CW = 8 * D;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso;
    logic       spi_cs_n;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = !clk;

    spi_byte_port #(.CLK_DIV(D)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n)
    );

    // Bench SPI slave: mode 0, answers byte k with pat(k + off)
    int         rises = 0;
    int         nbit  = 0;
    int         off   = 0;
    logic [7:0] sh    = 8'd0;
    logic [7:0] cap [0:1023];

    function automatic logic [7:0] pat(int k);
        return 8'((k * 37 + 90) & 255);
    endfunction

    always_comb begin
        logic [7:0] b;
        b = pat((nbit >> 3) + off);
        spi_miso = b[7 - (nbit & 7)];
    end

    always @(negedge spi_sclk) nbit = nbit + 1;

    always @(posedge spi_sclk) begin
        sh    = {sh[6:0], spi_mosi};
        rises = rises + 1;
        if ((rises % 8) == 0) cap[rises / 8 - 1] = sh;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit s, input bit w, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        drive(1'b1, 1'b0, a, 8'd0);
        #1 v = bus_rdata;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd2, v);
            if (v[0] == 1'b0) break;
        end
        idle();
    endtask

    // Sets the slave so that the next byte it sends is pat(base)
    task automatic slave_base(input int base);
        off = base - (nbit >> 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, hi, r0, b0;
        bit hold_seen;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        check(spi_cs_n == 1'b1, "R10 cs_n", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R10 sclk", spi_sclk, 0);
        check(spi_mosi == 1'b1, "R10 mosi", spi_mosi, 1);
        rd(2'd2, v); check(v == 8'h00, "R10 status", v, 0);
        rd(2'd0, v); check(v == 8'h00, "R10 rx", v, 0);
        idle();

        // R1 / R3: single write, busy length and SCLK high time
        slave_base(0); r0 = rises; b0 = rises / 8;
        drive(1'b1, 1'b1, 2'd0, 8'hA5);
        n = 0; hi = 0;
        for (int i = 0; i < 500; i++) begin
            rd(2'd2, v);
            if (v[0] == 1'b0) break;
            n++;
            if (spi_sclk) hi++;
        end
        idle();
        check(n == CW, "R3 busy cycles", n, CW);
        check(hi == 4 * D, "R3 sclk high cycles", hi, 4 * D);
        check(rises - r0 == 8, "R1 sclk edges", rises - r0, 8);
        check(cap[b0] == 8'hA5, "R1 mosi byte", cap[b0], 8'hA5);
        rd(2'd0, v); check(v == pat(0), "R1 rx byte", v, pat(0));
        idle();
        check(spi_sclk == 1'b0, "R4 sclk idle low", spi_sclk, 0);
        check(spi_mosi == 1'b1, "R4 mosi idle high", spi_mosi, 1);

        // R8: reading data register starts nothing
        r0 = rises;
        rd(2'd0, v); idle();
        repeat (CW + 4) @(negedge clk);
        check(rises == r0, "R8 read starts nothing", rises - r0, 0);
        rd(2'd0, v); check(v == pat(0), "R8 rx kept", v, pat(0));
        idle();

        // R2: pull read returns old byte, sends 0xFF
        slave_base(7); b0 = rises / 8;
        rd(2'd1, v); idle();
        check(v == pat(0), "R2 pull returns old rx", v, pat(0));
        wait_idle();
        check(cap[b0] == 8'hFF, "R2 sends ones", cap[b0], 8'hFF);
        rd(2'd0, v); check(v == pat(7), "R2 new rx", v, pat(7));
        idle();

        // R5: two writes back to back, no gap
        slave_base(20); b0 = rises / 8;
        drive(1'b1, 1'b1, 2'd0, 8'h3C);
        drive(1'b1, 1'b1, 2'd0, 8'hC3);
        n = 0; hold_seen = 0;
        for (int i = 0; i < 500; i++) begin
            rd(2'd2, v);
            if (i == 0) hold_seen = v[1];
            if (v[0] == 1'b0) break;
            n++;
        end
        idle();
        check(hold_seen, "R5 hold flag", hold_seen, 1);
        check(n == 2 * CW - 1, "R5 continuous busy", n, 2 * CW - 1);
        check(cap[b0] == 8'h3C, "R5 first byte", cap[b0], 8'h3C);
        check(cap[b0 + 1] == 8'hC3, "R5 second byte", cap[b0 + 1], 8'hC3);
        rd(2'd0, v); check(v == pat(21), "R5 rx last", v, pat(21));
        idle();

        // R6: third request with hold full is dropped
        slave_base(40); r0 = rises; b0 = rises / 8;
        drive(1'b1, 1'b1, 2'd0, 8'h11);
        drive(1'b1, 1'b1, 2'd0, 8'h22);
        drive(1'b1, 1'b1, 2'd0, 8'h33);
        wait_idle();
        repeat (CW) @(negedge clk);
        check(rises - r0 == 16, "R6 only two bytes", rises - r0, 16);
        check(cap[b0 + 1] == 8'h22, "R6 held byte kept", cap[b0 + 1], 8'h22);
        rd(2'd0, v); check(v == pat(41), "R6 rx", v, pat(41));
        idle();

        // R9: writes to pull and status addresses do nothing
        r0 = rises;
        drive(1'b1, 1'b1, 2'd1, 8'h00);
        drive(1'b1, 1'b1, 2'd2, 8'hFF);
        rd(2'd2, v); idle();
        repeat (CW + 4) @(negedge clk);
        check(rises == r0, "R9 no exchange", rises - r0, 0);
        rd(2'd2, v); check(v == 8'h00, "R9 status", v, 0);
        rd(2'd0, v); check(v == pat(41), "R9 rx kept", v, pat(41));
        idle();

        // R7: chip select control
        drive(1'b1, 1'b1, 2'd3, 8'hFE); idle();
        check(spi_cs_n == 1'b0, "R7 cs low", spi_cs_n, 0);
        rd(2'd3, v); check(v == 8'h00, "R7 readback 0", v, 0);
        drive(1'b1, 1'b1, 2'd3, 8'h01); idle();
        check(spi_cs_n == 1'b1, "R7 cs high", spi_cs_n, 1);
        rd(2'd3, v); check(v == 8'h01, "R7 readback 1", v, 1);
        idle();

        // R1 / R5 sweep: all byte values through the holding slot
        slave_base(100); r0 = rises; b0 = rises / 8;
        for (int val = 0; val < 256; val++) begin
            for (int i = 0; i < 500; i++) begin
                rd(2'd2, v);
                if (v[1] == 1'b0) break;
            end
            drive(1'b1, 1'b1, 2'd0, 8'(val));
        end
        idle();
        wait_idle();
        check(rises - r0 == 2048, "R5 sweep edge count", rises - r0, 2048);
        for (int val = 0; val < 256; val++) begin
            check(cap[b0 + val] == 8'(val), "R1 sweep byte", cap[b0 + val], val);
        end
        rd(2'd0, v); check(v == pat(355), "R1 sweep rx", v, pat(355));
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule